// File: doc/BRIEF.md
# Precise Writeback Ordering Gate

This block holds every in-flight micro-operation in program order in a small circular queue, no matter which execution pipeline runs it. The four pipeline classes are integer, load/store, FP add and FP multiply. Dispatch allocates the next queue slot and returns its index as the operation's tag. Each pipeline later reports the tag as resolved, either normally or with an exception. When a pipeline wants to write a result register, it presents the tag together with a hazard bit from the external scoreboard. The block grants the write only when that operation and every older operation in the queue, in every pipeline, have resolved normally.

A faster, younger operation therefore cannot write its register while an older, slower one may still fault. An operation that faults never gets a write grant. When a faulting operation becomes the oldest entry, the block raises a one-cycle flush carrying its tag and drops every entry. Entries retire from the oldest end, one per cycle, once they have written back or have no destination. The grant decision is combinational within the request cycle.

Top module: `wb_order_gate`

## Requirements
- R1: After reset the queue is empty: `disp_ready`=1, `disp_tag`=0, `flush`=0 and no `wb_gnt` bit is set.
- R2: Each accepted dispatch receives tag equal to the slot index, the tags count upward modulo DEPTH from where the queue last restarted; when DEPTH operations are in flight `disp_ready` is 0.
- R3: A resolution report (`res_valid[p]`, `res_tag[p]`, `res_exc[p]`=1 for exception) changes only an entry that is in flight and still unresolved; reports from several pipelines in the same cycle all take effect; reports to empty slots are ignored.
- R4: `wb_gnt[p]` is 1 only if `wb_req[p]`=1, `wb_hazard[p]`=0, and the tagged entry is in flight, resolved normally, has a destination and has not yet been granted.
- R5: A write is granted only if every older in-flight entry, whatever its pipeline, is resolved normally.
- R6: An entry resolved with an exception is never granted a write.
- R7: When the oldest entry is resolved with an exception, `flush`=1 and `flush_tag` is its tag for that cycle; `disp_ready` is 0 and no write is granted; on the next cycle the queue is empty and the next dispatch gets the faulting tag.
- R8: The oldest entry retires only after it has been granted its write or was resolved normally without a destination; at most one entry retires per cycle, and a younger resolved entry never retires past an unresolved older one.
- R9: `wb_rd[p]` shows the destination register recorded at dispatch for the entry named by `wb_tag[p]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_has_dst | input | 1 | Operation writes a register |
| disp_rd | input | RW | Destination register index |
| disp_ready | output | 1 | Dispatch accepted this cycle |
| disp_tag | output | TAGW | Tag assigned to the dispatched operation |
| res_valid | input | NPIPE | Per-pipeline resolution report |
| res_tag | input | NPIPE x TAGW | Tag being resolved |
| res_exc | input | NPIPE | Resolution carries an exception |
| wb_req | input | NPIPE | Per-pipeline writeback request |
| wb_tag | input | NPIPE x TAGW | Tag of the requesting operation |
| wb_hazard | input | NPIPE | External WAW/WAR hazard for the request |
| wb_gnt | output | NPIPE | Writeback granted |
| wb_rd | output | NPIPE x RW | Destination of the requested entry |
| flush | output | 1 | Oldest entry faulted; queue discarded |
| flush_tag | output | TAGW | Tag of the faulting entry |

## Verification
The bench places a slow FP-multiply operation at the head and lets two younger integer operations resolve first. It then checks that their write requests stall and stay stalled when the old operation faults. A gate that looked only at its own pipeline, or only at the scoreboard, would let them write early. The flush cycle is checked for tag, blocked dispatch and the restarted tag, and a stale exception report sent to an emptied slot must not trigger a later flush. The bench also fills the queue to its limit and shows that a resolved younger entry cannot retire past an unresolved older one, and a scoreboard of expected writes confirms that only the writes of the sequential program before the fault happen.

// File: rtl/wb_order_gate.sv
module wb_order_gate #(
  parameter int DEPTH = 16,
  parameter int NPIPE = 4,
  parameter int RW    = 5,
  localparam int TAGW = $clog2(DEPTH),
  localparam int CW   = TAGW + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        disp_valid,
  input  logic                        disp_has_dst,
  input  logic [RW-1:0]               disp_rd,
  output logic                        disp_ready,
  output logic [TAGW-1:0]             disp_tag,
  input  logic [NPIPE-1:0]            res_valid,
  input  logic [NPIPE-1:0][TAGW-1:0]  res_tag,
  input  logic [NPIPE-1:0]            res_exc,
  input  logic [NPIPE-1:0]            wb_req,
  input  logic [NPIPE-1:0][TAGW-1:0]  wb_tag,
  input  logic [NPIPE-1:0]            wb_hazard,
  output logic [NPIPE-1:0]            wb_gnt,
  output logic [NPIPE-1:0][RW-1:0]    wb_rd,
  output logic                        flush,
  output logic [TAGW-1:0]             flush_tag
);
  localparam logic [1:0] ST_PEND = 2'd0, ST_OK = 2'd1, ST_EXC = 2'd2;

  logic [DEPTH-1:0] live, has_dst, written, older_ok;
  logic [1:0]       st [DEPTH];
  logic [RW-1:0]    dst [DEPTH];
  logic [TAGW-1:0]  head, tail;
  logic [CW-1:0]    count;
  logic             push, retire;

  always_comb begin
    logic run;
    logic [TAGW-1:0] idx;
    run = 1'b1;
    older_ok = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head + TAGW'(k);
      older_ok[idx] = run;
      if (live[idx] && st[idx] != ST_OK) run = 1'b0;
    end
  end

  assign flush      = live[head] && st[head] == ST_EXC;
  assign flush_tag  = head;
  assign retire     = live[head] && st[head] == ST_OK && (written[head] || !has_dst[head]);
  assign disp_ready = (count != CW'(DEPTH)) && !flush;
  assign disp_tag   = tail;
  assign push       = disp_valid && disp_ready;

  for (genvar p = 0; p < NPIPE; p++) begin : g_pipe
    logic [TAGW-1:0] t;
    assign t = wb_tag[p];
    assign wb_rd[p]  = dst[t];
    assign wb_gnt[p] = wb_req[p] && !wb_hazard[p] && !flush && live[t] &&
                       st[t] == ST_OK && has_dst[t] && !written[t] && older_ok[t];

    a_r4_hazard_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      wb_hazard[p] |-> !wb_gnt[p]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live <= '0; has_dst <= '0; written <= '0;
      head <= '0; tail <= '0; count <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        st[i]  <= ST_PEND;
        dst[i] <= '0;
      end
    end else if (flush) begin
      live  <= '0;
      count <= '0;
      tail  <= head;
    end else begin
      for (int p = 0; p < NPIPE; p++) begin
        if (res_valid[p] && live[res_tag[p]] && st[res_tag[p]] == ST_PEND)
          st[res_tag[p]] <= res_exc[p] ? ST_EXC : ST_OK;
        if (wb_gnt[p]) written[wb_tag[p]] <= 1'b1;
      end
      if (push) begin
        live[tail]    <= 1'b1;
        st[tail]      <= ST_PEND;
        has_dst[tail] <= disp_has_dst;
        written[tail] <= 1'b0;
        dst[tail]     <= disp_rd;
        tail          <= tail + 1'b1;
      end
      if (retire) begin
        live[head] <= 1'b0;
        head       <= head + 1'b1;
      end
      count <= count + CW'(push) - CW'(retire);
    end
  end

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));
  a_r7_no_grant_on_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (wb_gnt == '0));
  a_r8_single_retire: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> (count + CW'(1) >= $past(count)));
endmodule

// File: tb/test_wb_order_gate.sv
`timescale 1ns/1ps
module test_wb_order_gate;
  localparam int DEPTH = 16, NPIPE = 4, RW = 5, TAGW = 4;

  logic clk = 0, rst_n = 0;
  logic disp_valid, disp_has_dst, disp_ready, flush;
  logic [RW-1:0] disp_rd;
  logic [TAGW-1:0] disp_tag, flush_tag;
  logic [NPIPE-1:0] res_valid, res_exc, wb_req, wb_hazard, wb_gnt;
  logic [NPIPE-1:0][TAGW-1:0] res_tag, wb_tag;
  logic [NPIPE-1:0][RW-1:0] wb_rd;

  int checks = 0, fails = 0;
  int exp_q[$];
  bit done = 0;

  always #2.5 clk = ~clk;

  wb_order_gate #(.DEPTH(DEPTH), .NPIPE(NPIPE), .RW(RW)) i_wb_order_gate (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_has_dst(disp_has_dst),
    .disp_rd(disp_rd), .disp_ready(disp_ready), .disp_tag(disp_tag),
    .res_valid(res_valid), .res_tag(res_tag), .res_exc(res_exc),
    .wb_req(wb_req), .wb_tag(wb_tag), .wb_hazard(wb_hazard), .wb_gnt(wb_gnt),
    .wb_rd(wb_rd), .flush(flush), .flush_tag(flush_tag));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear();
    disp_valid = 0; disp_has_dst = 0; disp_rd = '0;
    res_valid = '0; res_tag = '0; res_exc = '0;
    wb_req = '0; wb_tag = '0; wb_hazard = '0;
  endtask

  task automatic expect_write(input int tag, input int rd);
    exp_q.push_back(tag * 256 + rd);
  endtask

  task automatic next();
    @(negedge clk);
    clear();
  endtask

  always begin
    @(negedge clk);
    #1;
    if (rst_n)
      for (int p = 0; p < NPIPE; p++)
        if (wb_gnt[p]) begin
          if (exp_q.size() == 0)
            chk(0, "R5 unexpected write", int'(wb_tag[p]), -1);
          else begin
            int e;
            e = exp_q.pop_front();
            chk(int'(wb_tag[p]) == e / 256, "R4 write order tag", int'(wb_tag[p]), e / 256);
            chk(int'(wb_rd[p]) == e % 256, "R9 write destination", int'(wb_rd[p]), e % 256);
          end
        end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(disp_ready == 1, "R1 ready", disp_ready, 1);
    chk(disp_tag == 0, "R1 tag", disp_tag, 0);
    chk(flush == 0, "R1 flush", flush, 0);
    chk(wb_gnt == 0, "R1 grant", wb_gnt, 0);
    next();

    disp_valid = 1; disp_has_dst = 1; disp_rd = 5; #1;
    chk(disp_tag == 0, "R2 tag A", disp_tag, 0); next();
    disp_valid = 1; disp_has_dst = 1; disp_rd = 6; #1;
    chk(disp_tag == 1, "R2 tag B", disp_tag, 1); next();
    disp_valid = 1; disp_has_dst = 0; disp_rd = 0; #1;
    chk(disp_tag == 2, "R2 tag C", disp_tag, 2); next();

    res_valid[0] = 1; res_tag[0] = 1; next();
    wb_req[0] = 1; wb_tag[0] = 1; #1;
    chk(wb_gnt[0] == 0, "R5 younger waits on older", wb_gnt[0], 0); next();

    res_valid[3] = 1; res_tag[3] = 0; res_valid[1] = 1; res_tag[1] = 2; next();
    expect_write(0, 5);
    wb_req[3] = 1; wb_tag[3] = 0; wb_req[0] = 1; wb_tag[0] = 1; wb_hazard[0] = 1; #1;
    chk(wb_gnt[3] == 1, "R3 R4 same-cycle resolves grant", wb_gnt[3], 1);
    chk(wb_gnt[0] == 0, "R4 hazard stalls", wb_gnt[0], 0);
    next();
    expect_write(1, 6);
    wb_req[0] = 1; wb_tag[0] = 1; #1;
    chk(wb_gnt[0] == 1, "R4 grant after hazard clears", wb_gnt[0], 1); next();
    wb_req[2] = 1; wb_tag[2] = 0; #1;
    chk(wb_gnt[2] == 0, "R4 no second write", wb_gnt[2], 0); next();

    disp_valid = 1; disp_has_dst = 1; disp_rd = 7; #1;
    chk(disp_tag == 3, "R2 tag D", disp_tag, 3); next();
    disp_valid = 1; disp_has_dst = 1; disp_rd = 8; #1;
    chk(disp_tag == 4, "R2 tag E", disp_tag, 4); next();
    disp_valid = 1; disp_has_dst = 1; disp_rd = 9; #1;
    chk(disp_tag == 5, "R2 tag F", disp_tag, 5); next();

    res_valid[0] = 1; res_tag[0] = 4; res_valid[1] = 1; res_tag[1] = 5; next();
    wb_req[0] = 1; wb_tag[0] = 4; wb_req[1] = 1; wb_tag[1] = 5; #1;
    chk(wb_gnt == 0, "R5 other-pipe older unresolved", wb_gnt, 0); next();
    res_valid[3] = 1; res_tag[3] = 3; res_exc[3] = 1;
    wb_req[0] = 1; wb_tag[0] = 4; wb_req[1] = 1; wb_tag[1] = 5; next();

    wb_req = 4'b1011; wb_tag[0] = 4; wb_tag[1] = 5; wb_tag[3] = 3; disp_valid = 1; #1;
    chk(flush == 1, "R7 flush raised", flush, 1);
    chk(flush_tag == 3, "R7 flush tag", flush_tag, 3);
    chk(disp_ready == 0, "R7 dispatch blocked", disp_ready, 0);
    chk(wb_gnt == 0, "R6 no write for fault or younger", wb_gnt, 0);
    next();
    #1;
    chk(flush == 0, "R7 flush one cycle", flush, 0);
    chk(disp_tag == 3, "R7 restart tag", disp_tag, 3);
    chk(disp_ready == 1, "R7 ready after flush", disp_ready, 1);
    res_valid[2] = 1; res_tag[2] = 4; res_exc[2] = 1;
    next();

    for (int i = 0; i < DEPTH; i++) begin
      disp_valid = 1; #1;
      chk(disp_tag == TAGW'(3 + i), "R2 fill tag", disp_tag, (3 + i) % DEPTH);
      next();
    end
    #1;
    chk(disp_ready == 0, "R2 full stalls", disp_ready, 1'b0);
    res_valid[0] = 1; res_tag[0] = 3; res_valid[1] = 1; res_tag[1] = 5;
    next();
    #1;
    chk(disp_ready == 0, "R8 not yet retired", disp_ready, 0);
    next();
    #1;
    chk(disp_ready == 1, "R8 head retired", disp_ready, 1);
    chk(flush == 0, "R3 stale exception ignored", flush, 0);
    disp_valid = 1; #1;
    chk(disp_tag == 3, "R2 wrap tag", disp_tag, 3);
    next();
    next();
    #1;
    chk(disp_ready == 0, "R8 no retire past unresolved", disp_ready, 0);
    res_valid[2] = 1; res_tag[2] = 4;
    next();
    next();
    #1;
    chk(disp_ready == 1, "R8 in-order drain", disp_ready, 1);
    next();

    chk(exp_q.size() == 0, "R5 sequential writes done", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule